// File: doc/BRIEF.md
# Stop-Clock Low-Power Sequencer

This block sequences a processor core into and out of a low-power stop-grant state. A raw, active-low stop request arrives asynchronously to the bus clock. It passes through a synchronizer and a stability filter. Once the request is accepted, the block asks the bus unit to issue a stop-grant acknowledge transaction. It holds that request until the bus unit reports that the transaction went out, and only then drops the clock enables of the core domains.

The bus-interface and interrupt-controller domains keep their enables high at all times, so snooping and interrupt service carry on while the core is stopped. When the request is released, the block raises every core enable again and flags resume for one cycle before it returns to normal running. The bus clock itself is never gated by this block.

Top module: `stopclk_seq`

## Requirements
- R1: While rst_ni is low and after it is released, ack_req_o, stopped_o and resume_o are 0 and every bit of core_en_o, bus_en_o and irq_en_o is 1.
- R2: stop_req_ni is accepted only after two synchronizer flops and two consecutive synchronized cycles of the same level. When the pin goes low just after a falling clock edge, ack_req_o is still 0 after the fourth rising edge and is 1 after the fifth.
- R3: A low level on stop_req_ni that lasts one clock period is ignored: ack_req_o stays 0 and core_en_o stays all ones.
- R4: Once raised, ack_req_o stays 1 until a cycle with ack_done_i = 1. All core enables stay 1 while it is raised.
- R5: When ack_done_i is 1 with ack_req_o raised and the accepted request still active, then after the next rising edge stopped_o = 1, core_en_o is all zeros and ack_req_o = 0.
- R6: bus_en_o and irq_en_o are 1 in every state, including while stopped_o = 1.
- R7: When stop_req_ni returns high while stopped, stopped_o falls and core_en_o becomes all ones on the fifth rising edge. resume_o is 1 for exactly that one cycle, and the block then runs with resume_o = 0.
- R8: If the accepted request is withdrawn while ack_req_o is raised, the block keeps ack_req_o until ack_done_i. It then goes straight to resume (resume_o = 1 for one cycle) without ever asserting stopped_o or clearing core_en_o.
- R9: ack_done_i has no effect while ack_req_o is 0: it neither raises ack_req_o nor stopped_o nor clears any core enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, always running |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_req_ni | input | 1 | Raw asynchronous stop request, active low |
| ack_done_i | input | 1 | Bus unit reports that the stop-grant acknowledge was issued |
| core_en_o | output | N_CORE | Clock enables of the core domains |
| bus_en_o | output | 1 | Clock enable of the bus-interface domain |
| irq_en_o | output | 1 | Clock enable of the interrupt-controller domain |
| ack_req_o | output | 1 | Request to issue the stop-grant acknowledge transaction |
| stopped_o | output | 1 | Core domains are gated |
| resume_o | output | 1 | One-cycle flag marking the restart of the core domains |

## Verification
The hardest situation to reach is a request withdrawn while the acknowledge is still outstanding. The release has to pass the full synchronizer and filter delay before the bus unit answers. The bench drives the pin low and waits for ack_req_o. It then raises the pin again and holds ack_done_i low for several cycles, so the filtered request drops inside the pending state. Only then does it pulse ack_done_i, and it checks that the block resumes without ever gating the core. Single-period glitches are made by changing the pin on consecutive falling edges, so exactly one synchronizer sample sees the low level.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_ACK     = 2'd1,
    ST_STOP    = 2'd2,
    ST_RESTART = 2'd3
  } stc_state_e;
endpackage

// File: rtl/stopclk_sync.sv
module stopclk_sync #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic req_o
);
  localparam int unsigned CNT_W = $clog2(FILT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   req_s;
  logic                   req_q;
  logic [CNT_W-1:0]       cnt_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= req_ni;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], req_ni};
      end
    end
  endgenerate

  assign req_s = ~sync_q[SYNC_STAGES-1];

  // accept a new level only after FILT_CYCLES consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      cnt_q <= '0;
    end else if (req_s != req_q) begin
      if (cnt_q == CNT_MAX) begin
        req_q <= req_s;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign req_o = req_q;

  AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q != $past(req_q)) |-> ($past(req_s) == req_q)); // R2

endmodule

// File: rtl/stopclk_fsm.sv
module stopclk_fsm
  import stopclk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ack_done_i,
  output logic core_on_o,
  output logic ack_req_o,
  output logic stopped_o,
  output logic resume_o
);
  stc_state_e state_q, state_d;
  logic       core_on_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:     if (req_i) state_d = ST_ACK;
      ST_ACK:     if (ack_done_i) state_d = req_i ? ST_STOP : ST_RESTART;
      ST_STOP:    if (!req_i) state_d = ST_RESTART;
      ST_RESTART: state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      core_on_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      core_on_q <= (state_d != ST_STOP);
    end
  end

  assign core_on_o = core_on_q;
  assign ack_req_o = (state_q == ST_ACK);
  assign stopped_o = (state_q == ST_STOP);
  assign resume_o  = (state_q == ST_RESTART);

  AST_STOP_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stopped_o) |-> $past(req_i)); // R5
  AST_WITHDRAW_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_req_o && ack_done_i && !req_i) |=> (resume_o && !stopped_o)); // R8

endmodule

// File: rtl/stopclk_gate.sv
module stopclk_gate #(
  parameter int unsigned N_CORE = 4
) (
  input  logic              core_on_i,
  output logic [N_CORE-1:0] core_en_o,
  output logic              bus_en_o,
  output logic              irq_en_o
);
  for (genvar i = 0; i < N_CORE; i++) begin : g_core
    assign core_en_o[i] = core_on_i;
  end

  // snoop and interrupt domains are never gated
  assign bus_en_o = 1'b1;
  assign irq_en_o = 1'b1;

endmodule

// File: rtl/stopclk_seq.sv
module stopclk_seq #(
  parameter int unsigned N_CORE      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_req_ni,
  input  logic              ack_done_i,
  output logic [N_CORE-1:0] core_en_o,
  output logic              bus_en_o,
  output logic              irq_en_o,
  output logic              ack_req_o,
  output logic              stopped_o,
  output logic              resume_o
);
  logic req_f;
  logic core_on;

  stopclk_sync #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_CYCLES(FILT_CYCLES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_ni(stop_req_ni),
    .req_o (req_f)
  );

  stopclk_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_f),
    .ack_done_i(ack_done_i),
    .core_on_o (core_on),
    .ack_req_o (ack_req_o),
    .stopped_o (stopped_o),
    .resume_o  (resume_o)
  );

  stopclk_gate #(.N_CORE(N_CORE)) u_gate (
    .core_on_i(core_on),
    .core_en_o(core_en_o),
    .bus_en_o (bus_en_o),
    .irq_en_o (irq_en_o)
  );

  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_req_o && !ack_done_i) |=> ack_req_o); // R4
  AST_CORE_ON_WHILE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_o |-> (core_en_o == '1)); // R4
  AST_GATE_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_en_o[0]) |-> ($past(ack_req_o) && $past(ack_done_i))); // R5
  AST_RESUME_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o); // R7
  AST_NO_FLAG_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ack_req_o, stopped_o, resume_o})); // R5

endmodule

// File: tb/stopclk_seq_bench.sv
module stopclk_seq_bench;
  localparam int N_CORE = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              stop_req_n = 1'b1;
  logic              ack_done = 1'b0;
  logic [N_CORE-1:0] core_en;
  logic              bus_en, irq_en, ack_req, stopped, resume;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  stopclk_seq #(.N_CORE(N_CORE)) u_stopclk_seq (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .stop_req_ni(stop_req_n),
    .ack_done_i (ack_done),
    .core_en_o  (core_en),
    .bus_en_o   (bus_en),
    .irq_en_o   (irq_en),
    .ack_req_o  (ack_req),
    .stopped_o  (stopped),
    .resume_o   (resume)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 ack_req in reset", 32'(ack_req), 0);
    chk("R1 core_en in reset", 32'(core_en), 32'hF);
    @(negedge clk) rst_n = 1'b1;
    edges(2);
    chk("R1 ack_req", 32'(ack_req), 0);
    chk("R1 stopped", 32'(stopped), 0);
    chk("R1 resume", 32'(resume), 0);
    chk("R1 core_en", 32'(core_en), 32'hF);
    chk("R1 bus/irq en", 32'({bus_en, irq_en}), 32'h3);
  endtask

  task automatic t_glitch;
    stop_req_n = 1'b0;
    @(negedge clk) stop_req_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      edges(1);
      chk("R3 glitch ack_req", 32'(ack_req), 0);
    end
    chk("R3 glitch core_en", 32'(core_en), 32'hF);
  endtask

  task automatic t_ack_ignored;
    ack_done = 1'b1;
    edges(1);
    ack_done = 1'b0;
    edges(1);
    chk("R9 ack_req", 32'(ack_req), 0);
    chk("R9 stopped", 32'(stopped), 0);
    chk("R9 core_en", 32'(core_en), 32'hF);
  endtask

  task automatic t_entry;
    stop_req_n = 1'b0;
    edges(4);
    chk("R2 ack_req after 4 edges", 32'(ack_req), 0);
    edges(1);
    chk("R2 ack_req after 5 edges", 32'(ack_req), 1);
    edges(5);
    chk("R4 ack_req held", 32'(ack_req), 1);
    chk("R4 core_en while pending", 32'(core_en), 32'hF);
    ack_done = 1'b1;
    edges(1);
    ack_done = 1'b0;
    chk("R5 stopped", 32'(stopped), 1);
    chk("R5 core_en gated", 32'(core_en), 0);
    chk("R5 ack_req cleared", 32'(ack_req), 0);
    chk("R6 bus/irq en while stopped", 32'({bus_en, irq_en}), 32'h3);
    ack_done = 1'b1;
    edges(1);
    ack_done = 1'b0;
    chk("R9 ack_done while stopped", 32'({stopped, ack_req}), 32'h2);
  endtask

  task automatic t_release;
    stop_req_n = 1'b1;
    edges(4);
    chk("R7 still stopped after 4 edges", 32'(stopped), 1);
    edges(1);
    chk("R7 stopped low", 32'(stopped), 0);
    chk("R7 core_en on", 32'(core_en), 32'hF);
    chk("R7 resume pulse", 32'(resume), 1);
    edges(1);
    chk("R7 resume cleared", 32'(resume), 0);
    chk("R7 running", 32'({ack_req, stopped}), 0);
  endtask

  task automatic t_withdraw;
    bit saw_stop = 0;
    bit saw_gate = 0;
    stop_req_n = 1'b0;
    edges(5);
    chk("R8 pending", 32'(ack_req), 1);
    stop_req_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      edges(1);
      if (stopped) saw_stop = 1;
      if (core_en != '1) saw_gate = 1;
    end
    chk("R8 ack_req held after withdraw", 32'(ack_req), 1);
    ack_done = 1'b1;
    edges(1);
    ack_done = 1'b0;
    chk("R8 resume", 32'(resume), 1);
    chk("R8 stopped", 32'(stopped), 0);
    chk("R8 core_en", 32'(core_en), 32'hF);
    edges(1);
    chk("R8 back to run", 32'({resume, ack_req, stopped}), 0);
    chk("R8 never stopped/gated", 32'({saw_stop, saw_gate}), 0);
  endtask

  initial begin
    edges(3);
    t_reset();
    t_glitch();
    t_ack_ignored();
    t_entry();
    t_release();
    edges(3);
    t_withdraw();
    edges(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule